// File: doc/BRIEF.md
# Divided Countdown Timer

A one-shot countdown timer for a local interrupt controller. Software first programs a 4-bit divide-configuration register, then writes a 32-bit initial count. The write starts a countdown that falls by one once per divided clock period. When the countdown reaches zero, the block emits a one-cycle expiry strobe and goes idle. Vector delivery and masking are handled by a neighbouring block that consumes the strobe.

Access is through a simple write port and a registered read port on a 2-bit address. Address 0 is the initial count, address 1 is the read-only current count, address 2 is the divide configuration, and address 3 is reserved. The current count always reports the remaining time in whole divided periods, rounded up. While nothing is running it reads zero.

Top module: `divcount_timer`

## Requirements
- R1: The divisor D is 2 to the power s. Here s is the 3-bit value {cfg[3], cfg[1], cfg[0]} plus one, modulo 8. Code 0xB gives D=1, code 0x0 gives D=2, code 0x1 gives D=4, and code 0xA gives D=128.
- R2: A write to address 2 stores only the data bits under mask 0xB. A read of address 2 returns that value zero-extended, so bit 2 always reads zero. After reset it reads 0.
- R3: A write of a nonzero value N to address 0 loads all 32 bits and restarts the countdown at once, even when a countdown is already running. A read of address 1 sampled one edge after the load edge returns N.
- R4: The expiry strobe is high in exactly the cycle that follows the clock edge N*D edges after the load edge, provided D is unchanged during the run.
- R5: During a run, address 1 reads ceil(R/D), where R is the number of input clocks left before expiry. When idle, and after reset, it reads 0.
- R6: Writes to address 1 have no effect on the countdown.
- R7: The expiry strobe lasts one cycle. Afterwards the current count reads 0 and no further strobe occurs.
- R8: Writing 0 to address 0 starts nothing and gives no strobe. If a countdown is running, the write stops it and the current count reads 0.
- R9: A change of divide configuration during a run first applies when the prescaler next wraps. With D=4, N=3 and a switch to code 0xB one edge after the load, the strobe follows the 6th edge after the load.
- R10: rd_data is registered. It shows the register selected at the previous edge, and address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 32 | Registered read data |
| expire | output | 1 | One-cycle expiry strobe |

## Verification
Let L be the load edge. A load at L shows up in rd_data after edge L+1. In general, rd_data sampled j edges after L reflects the state j-1 edges after the load. The strobe shows up right after edge L+N*D. The bench drives inputs and samples outputs on falling edges, and counts edges from L. Each sample is compared with ceil((N*D-(j-1))/D) for the count and with (j == N*D) for the strobe. Register reads are sampled one edge after the address is presented.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SHIFT_W = 3;
  localparam int CFG_W   = 4;
  localparam logic [CFG_W-1:0] CFG_MASK = 4'hB;

  localparam logic [1:0] ADDR_INIT = 2'd0;
  localparam logic [1:0] ADDR_CUR  = 2'd1;
  localparam logic [1:0] ADDR_DIV  = 2'd2;
  localparam logic [1:0] ADDR_RSV  = 2'd3;

  // Shift amount: {cfg3,cfg1,cfg0} + 1, wrapping in 3 bits
  function automatic logic [SHIFT_W-1:0] cfg_to_shift(input logic [CFG_W-1:0] cfg);
    logic [SHIFT_W-1:0] raw;
    raw = {cfg[3], cfg[1], cfg[0]};
    return raw + 3'd1;
  endfunction
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [CNT_W-1:0]   wr_data,
  input  logic [1:0]         rd_addr,
  input  logic [CNT_W-1:0]   cur_cnt,
  output logic [SHIFT_W-1:0] shift,
  output logic               load,
  output logic [CNT_W-1:0]   load_val,
  output logic [CNT_W-1:0]   rd_data
);
  logic [CFG_W-1:0] div_cfg;
  logic [CNT_W-1:0] init_q;

  assign load     = wr_en && (wr_addr == ADDR_INIT);
  assign load_val = wr_data;
  assign shift    = cfg_to_shift(div_cfg);

  always_ff @(posedge clk) begin
    if (rst) begin
      div_cfg <= '0;
      init_q  <= '0;
    end else if (wr_en) begin
      if (wr_addr == ADDR_DIV)  div_cfg <= wr_data[CFG_W-1:0] & CFG_MASK;
      if (wr_addr == ADDR_INIT) init_q  <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else begin
      case (rd_addr)
        ADDR_INIT: rd_data <= init_q;
        ADDR_CUR:  rd_data <= cur_cnt;
        ADDR_DIV:  rd_data <= {{(CNT_W-CFG_W){1'b0}}, div_cfg};
        default:   rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr_prescale.sv
module tmr_prescale
  import tmr_pkg::*;
#(
  parameter int PRE_W = (1 << SHIFT_W) - 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load,
  input  logic               running,
  input  logic [SHIFT_W-1:0] shift,
  output logic               tick
);
  logic [PRE_W-1:0] pre;
  logic [PRE_W-1:0] reload;

  // divisor minus one, taken from the live configuration
  assign reload = ~({PRE_W{1'b1}} << shift);
  assign tick   = running && !load && (pre == '0);

  always_ff @(posedge clk) begin
    if (rst)                pre <= '0;
    else if (load)          pre <= reload;
    else if (running) begin
      if (pre == '0)        pre <= reload;
      else                  pre <= pre - 1'b1;
    end
  end

  // R9: between wraps the prescaler only steps down by one
  p_pre_step_r9: assert property (@(posedge clk) disable iff (rst)
    (running && !load && !tick) |=> (pre == $past(pre) - 1'b1));
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt,
  output logic             running,
  output logic             expire
);
  assign running = (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      expire <= 1'b0;
    end else begin
      expire <= 1'b0;
      if (load) begin
        cnt <= load_val;
      end else if (tick) begin
        cnt <= cnt - 1'b1;
        if (cnt == {{(CNT_W-1){1'b0}}, 1'b1}) expire <= 1'b1;
      end
    end
  end

  p_hold_between_ticks_r5: assert property (@(posedge clk) disable iff (rst)
    (!load && !tick) |=> $stable(cnt));
  p_expire_from_one_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(expire) |-> ($past(cnt) == {{(CNT_W-1){1'b0}}, 1'b1} && cnt == '0));
  p_single_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    expire |=> !expire);
  p_zero_load_r8: assert property (@(posedge clk) disable iff (rst)
    (load && load_val == '0) |=> (cnt == '0 && !expire));
endmodule

// File: rtl/divcount_timer.sv
module divcount_timer
  import tmr_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [1:0]       wr_addr,
  input  logic [CNT_W-1:0] wr_data,
  input  logic [1:0]       rd_addr,
  output logic [CNT_W-1:0] rd_data,
  output logic             expire
);
  localparam int PRE_W = (1 << SHIFT_W) - 1;

  logic [SHIFT_W-1:0] shift;
  logic               load;
  logic [CNT_W-1:0]   load_val;
  logic [CNT_W-1:0]   cnt;
  logic               running;
  logic               tick;

  tmr_regs #(.CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .cur_cnt(cnt), .shift(shift), .load(load),
    .load_val(load_val), .rd_data(rd_data)
  );

  tmr_prescale #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .load(load), .running(running), .shift(shift), .tick(tick)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load), .load_val(load_val), .tick(tick),
    .cnt(cnt), .running(running), .expire(expire)
  );

  // R3: a load replaces the count on the next edge, whatever was running
  p_load_restart_r3: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(wr_data)));
  // R6: a write to the read-only address leaves the count alone between ticks
  p_cur_write_ignored_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_CUR && !tick) |=> $stable(cnt));
endmodule

// File: tb/sim_divcount_timer.sv
module sim_divcount_timer;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [1:0]  rd_addr = 2'd1;
  logic [31:0] rd_data;
  logic        expire;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  divcount_timer u0 (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .expire(expire)
  );

  function automatic longint div_of(input logic [3:0] code);
    logic [2:0] s;
    s = {code[3], code[1], code[0]} + 3'd1;
    return longint'(1) << s;
  endfunction

  function automatic longint exp_count(input longint n, input longint d, input longint k);
    if (k >= n * d) return 0;
    return (n * d - k + d - 1) / d;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] v);
    rd_addr = a;
    @(negedge clk);
    v = rd_data;
    rd_addr = 2'd1;
  endtask

  // called right after the load write (j = 0)
  task automatic run_check(input longint n, input logic [3:0] code, input string tag);
    longint d;
    d = div_of(code);
    for (longint j = 1; j <= n * d + 3; j++) begin
      @(negedge clk);
      chk(rd_data == 32'(exp_count(n, d, j - 1)), "R5 count", rd_data, exp_count(n, d, j - 1));
      if (j <= n * d)
        chk(expire == (j == n * d), tag, expire, (j == n * d));
      else
        chk(expire == 1'b0, "R7 strobe after end", expire, 0);
    end
    chk(rd_data == 0, "R7 idle count", rd_data, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [3:0]  code;
    longint      n;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk(expire == 1'b0, "R7 reset strobe", expire, 0);
    rd(2'd1, v); chk(v == 0, "R5 reset count", v, 0);
    rd(2'd2, v); chk(v == 0, "R2 reset div", v, 0);

    // divide register mask
    wr(2'd2, 32'hFFFF_FFFF);
    rd(2'd2, v); chk(v == 32'hB, "R2 mask 0xB", v, 32'hB);
    wr(2'd2, 32'h4);
    rd(2'd2, v); chk(v == 0, "R2 bit2 reads zero", v, 0);
    rd(2'd3, v); chk(v == 0, "R10 reserved address", v, 0);

    // decode corners
    wr(2'd2, 32'hB); wr(2'd0, 32'd5); run_check(5, 4'hB, "R1 div1 expiry");
    wr(2'd2, 32'h0); wr(2'd0, 32'd3); run_check(3, 4'h0, "R1 div2 expiry");
    wr(2'd2, 32'hA); wr(2'd0, 32'd2); run_check(2, 4'hA, "R1 div128 expiry");

    // full-width load
    wr(2'd2, 32'hB); wr(2'd0, 32'hF000_0001);
    @(negedge clk); chk(rd_data == 32'hF000_0001, "R3 full width load", rd_data, 32'hF000_0001);
    rd(2'd0, v); chk(v == 32'hF000_0001, "R10 init readback", v, 32'hF000_0001);

    // zero while running stops it
    wr(2'd0, 32'd0);
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      chk(expire == 1'b0, "R8 stop no strobe", expire, 0);
    end
    chk(rd_data == 0, "R8 stopped count", rd_data, 0);
    // zero while idle
    wr(2'd0, 32'd0);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(expire == 1'b0, "R8 idle zero load", expire, 0);
    end

    // restart mid run
    wr(2'd2, 32'h0); wr(2'd0, 32'd4);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(expire == 1'b0, "R3 early strobe", expire, 0);
    end
    wr(2'd0, 32'd2); run_check(2, 4'h0, "R3 restart expiry");

    // write to read-only current count during a run
    wr(2'd0, 32'd5);
    wr(2'd1, 32'h99);
    for (longint j = 2; j <= 12; j++) begin
      @(negedge clk);
      chk(rd_data == 32'(exp_count(5, 2, j - 1)), "R6 count after ro write", rd_data, exp_count(5, 2, j - 1));
      chk(expire == (j == 10), "R6 expiry after ro write", expire, (j == 10));
    end

    // divider change mid run: D=4, N=3, switch to div1 one edge in
    wr(2'd2, 32'h1); wr(2'd0, 32'd3);
    wr(2'd2, 32'hB);
    chk(expire == 1'b0, "R9 early", expire, 0);
    for (int j = 2; j <= 9; j++) begin
      @(negedge clk);
      chk(expire == (j == 6), "R9 expiry edge", expire, (j == 6));
      if (j == 5) chk(rd_data == 2, "R9 count", rd_data, 2);
    end

    // random runs
    for (int r = 0; r < 16; r++) begin
      code = 4'($urandom % 16);
      n = 1 + longint'($urandom % 12);
      wr(2'd2, {28'd0, code});
      wr(2'd0, 32'(n));
      run_check(n, code, "R4 expiry");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule